// File: doc/BRIEF.md
# Accumulator ALU with Selective Status Flags

This block is the byte-wide arithmetic and logic stage of an accumulator-style microcontroller datapath. On each enabled clock it takes a 4-bit operation code, the accumulator value and an operand byte, and it registers a result byte. It also holds the program status flags in an 8-bit register. The incoming carry used by add-with-carry, subtract and the carry rotates is the carry bit held in that register.

Flags follow a selective update policy. Only addition, addition with carry and subtraction rewrite carry, auxiliary carry and overflow. Compare writes carry alone and keeps the result register unchanged. The two carry rotates move a bit through carry. Every other operation leaves the status word exactly as it was. Subtraction always consumes the held carry as a borrow, and no borrow-free subtract exists. Operand fetch, addressing, memory, multiply, divide and decimal adjust all belong to neighbouring logic.

Top module: `acc_alu`

## Requirements
- R1: While rst_n is low, result and status are both 0x00. The reset is asynchronous on assertion.
- R2: When en is low at a clock edge, result and status keep their values.
- R3: ADD (code 0x0) gives result = acc + opnd mod 256. ADDC (code 0x1) also adds status bit 7 (carry). Both set status bit 7 to the carry out of bit 7, status bit 6 (auxiliary carry) to the carry out of bit 3, and status bit 2 (overflow) to the signed two's-complement overflow.
- R4: SUBB (code 0x2) gives result = acc - opnd - carry mod 256. It sets bit 7 to the borrow out of the full byte, bit 6 to the borrow out of the low nibble, and bit 2 to the signed overflow of the subtraction.
- R5: OR (0x3), AND (0x4), XOR (0x5), INC (0x6), DEC (0x7), RL (0x8), RR (0xA) and SWAP (0xC) leave all status bits unchanged. The three logic codes give acc|opnd, acc&opnd and acc^opnd.
- R6: INC gives acc+1 and DEC gives acc-1, both wrapping modulo 256 (0xFF→0x00, 0x00→0xFF).
- R7: CMP (code 0xD) sets carry to 1 exactly when acc < opnd (unsigned, with no carry-in). It leaves bits 6 and 2 and the result register unchanged.
- R8: RL gives acc shifted left by one with bit 0 = 0, equal to ADD of acc to itself. RLC (code 0x9) gives {acc[6:0], carry} and loads acc[7] into carry.
- R9: RR gives {acc[0], acc[7:1]}. RRC (code 0xB) gives {carry, acc[7:1]} and loads acc[0] into carry.
- R10: SWAP gives {acc[3:0], acc[7:4]}.
- R11: Status bits 5, 4, 3, 1 and 0 always read 0.
- R12: Codes 0xE and 0xF change neither result nor status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Update enable for result and status |
| op | input | 4 | Operation code |
| acc | input | 8 | Accumulator value (first operand) |
| opnd | input | 8 | Operand byte (second operand) |
| result | output | 8 | Registered result byte |
| status | output | 8 | Status word: bit 7 carry, bit 6 auxiliary carry, bit 2 overflow |

## Verification
The hardest situation to bring about is an operation whose outcome depends on flag history. An ADDC, SUBB or carry rotate reads a carry that an earlier ADD, SUBB, CMP or rotate left behind, possibly across flag-neutral operations and disabled cycles in between. The stimulus first runs directed sequences that set carry, then runs flag-neutral ops and idle cycles, and then consumes the carry. A long random run with random enables follows, so that flag-producing and flag-consuming operations interleave in many orders. A behavioural model that tracks the status word over the whole run is compared against the design on every clock.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DW     = 8;
  localparam int CY_BIT = 7;
  localparam int AC_BIT = 6;
  localparam int OV_BIT = 2;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_ADDC = 4'h1,
    OP_SUBB = 4'h2,
    OP_OR   = 4'h3,
    OP_AND  = 4'h4,
    OP_XOR  = 4'h5,
    OP_INC  = 4'h6,
    OP_DEC  = 4'h7,
    OP_RL   = 4'h8,
    OP_RLC  = 4'h9,
    OP_RR   = 4'hA,
    OP_RRC  = 4'hB,
    OP_SWAP = 4'hC,
    OP_CMP  = 4'hD,
    OP_NOPE = 4'hE,
    OP_NOPF = 4'hF
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } flags_t;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         cy,
  output logic         ac,
  output logic         ov
);
  localparam int H = W / 2;

  logic [W:0] full;
  logic [H:0] half;

  always_comb begin
    if (sub) begin
      full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
      half = {1'b0, a[H-1:0]} - {1'b0, b[H-1:0]} - {{H{1'b0}}, cin};
      ov   = (a[W-1] != b[W-1]) && (full[W-1] != a[W-1]);
    end else begin
      full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      half = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};
      ov   = (a[W-1] == b[W-1]) && (full[W-1] != a[W-1]);
    end
    res = full[W-1:0];
    cy  = full[W];
    ac  = half[H];
  end
endmodule

// File: rtl/alu_misc.sv
module alu_misc
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  localparam int H = W / 2;

  always_comb begin
    res  = a;
    cout = cin;
    unique case (op)
      OP_OR:   res = a | b;
      OP_AND:  res = a & b;
      OP_XOR:  res = a ^ b;
      OP_INC:  res = a + {{(W-1){1'b0}}, 1'b1};
      OP_DEC:  res = a - {{(W-1){1'b0}}, 1'b1};
      OP_RL:   res = {a[W-2:0], 1'b0};
      OP_RLC: begin
        res  = {a[W-2:0], cin};
        cout = a[W-1];
      end
      OP_RR:   res = {a[0], a[W-1:1]};
      OP_RRC: begin
        res  = {cin, a[W-1:1]};
        cout = a[0];
      end
      OP_SWAP: res = {a[H-1:0], a[W-1:H]};
      default: res = a;
    endcase
  end
endmodule

// File: rtl/alu_status.sv
module alu_status
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_cy,
  input  logic         we_av,
  input  flags_t       fl_d,
  output logic [W-1:0] status
);
  flags_t fl_q, fl_n;

  always_comb begin
    fl_n = fl_q;
    if (we_cy) fl_n.cy = fl_d.cy;
    if (we_av) begin
      fl_n.ac = fl_d.ac;
      fl_n.ov = fl_d.ov;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_q <= '0;
    else        fl_q <= fl_n;
  end

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      if (gi == CY_BIT) begin : g_cy
        assign status[gi] = fl_q.cy;
      end else if (gi == AC_BIT) begin : g_ac
        assign status[gi] = fl_q.ac;
      end else if (gi == OV_BIT) begin : g_ov
        assign status[gi] = fl_q.ov;
      end else begin : g_zero
        assign status[gi] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import alu_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [3:0]   op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] result,
  output logic [W-1:0] status
);
  alu_op_e     op_e;
  logic        cy_now;
  logic        ar_cin, ar_sub, ar_cy, ar_ac, ar_ov;
  logic [W-1:0] ar_res, mi_res, res_q, res_n;
  logic        mi_cout;
  logic        is_arith, is_cmp, is_crot, writes_res;
  logic        we_cy, we_av;
  flags_t      fl_d;

  assign op_e   = alu_op_e'(op);
  assign cy_now = status[CY_BIT];

  // Operation class decode
  always_comb begin
    is_arith   = (op_e == OP_ADD) || (op_e == OP_ADDC) || (op_e == OP_SUBB);
    is_cmp     = (op_e == OP_CMP);
    is_crot    = (op_e == OP_RLC) || (op_e == OP_RRC);
    writes_res = !is_cmp && (op_e != OP_NOPE) && (op_e != OP_NOPF);
    ar_sub     = (op_e == OP_SUBB) || is_cmp;
    ar_cin     = ((op_e == OP_ADDC) || (op_e == OP_SUBB)) ? cy_now : 1'b0;
  end

  alu_arith #(.W(W)) i_arith (
    .a(acc), .b(opnd), .cin(ar_cin), .sub(ar_sub),
    .res(ar_res), .cy(ar_cy), .ac(ar_ac), .ov(ar_ov)
  );

  alu_misc #(.W(W)) i_misc (
    .op(op_e), .a(acc), .b(opnd), .cin(cy_now),
    .res(mi_res), .cout(mi_cout)
  );

  // Flag write enables and data
  always_comb begin
    we_cy   = en && (is_arith || is_cmp || is_crot);
    we_av   = en && is_arith;
    fl_d.cy = is_crot ? mi_cout : ar_cy;
    fl_d.ac = ar_ac;
    fl_d.ov = ar_ov;
  end

  alu_status #(.W(W)) i_status (
    .clk(clk), .rst_n(rst_n), .we_cy(we_cy), .we_av(we_av),
    .fl_d(fl_d), .status(status)
  );

  // Result register: next state
  always_comb begin
    res_n = res_q;
    if (en && writes_res) res_n = is_arith ? ar_res : mi_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_n;
  end

  assign result = res_q;

  // R2: idle cycle holds all state
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(result) && $stable(status)));

  // R5: flag-neutral operations keep the status word
  p_flags_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op_e inside {OP_OR, OP_AND, OP_XOR, OP_INC, OP_DEC, OP_RL, OP_RR, OP_SWAP}))
    |=> $stable(status));

  // R7: compare keeps result, auxiliary carry and overflow
  p_cmp_carry_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_e == OP_CMP) |=> ($stable(result) && $stable(status[AC_BIT])
                                && $stable(status[OV_BIT])));

  // R7: compare carry reflects unsigned less-than
  p_cmp_lt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_e == OP_CMP) |=> (status[CY_BIT] == $past(acc < opnd)));

  // R6: increment of all-ones wraps to zero
  p_inc_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_e == OP_INC && acc == {W{1'b1}}) |=> (result == '0));

  // R12: unused codes change nothing
  p_unused_noop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op_e == OP_NOPE || op_e == OP_NOPF)) |=> ($stable(result) && $stable(status)));
endmodule

// File: tb/test_acc_alu.sv
module test_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] op = 4'h0;
  logic [7:0] acc = 8'h00;
  logic [7:0] opnd = 8'h00;
  logic [7:0] result, status;

  int total = 0;
  int bad = 0;
  int m_res = 0;
  int m_st = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  acc_alu i_acc_alu (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op),
    .acc(acc), .opnd(opnd), .result(result), .status(status)
  );

  task automatic chk(input string t, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%02h expected=%02h", t, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(tag, "result", int'(result), m_res);
    chk(tag, "status", int'(status), m_st);
    chk("R11", "spare status bits", int'(status) & 8'h3B, 0);
  endtask

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // Behavioural model of one enabled or idle clock
  task automatic model(input bit e, input int o, input int a, input int b);
    int cy, ac, ov, s, ss, r;
    cy = (m_st >> 7) & 1;
    ac = (m_st >> 6) & 1;
    ov = (m_st >> 2) & 1;
    r  = m_res;
    if (!e) begin
      tag = "R2";
    end else begin
      case (o)
        0, 1: begin
          int c = (o == 1) ? cy : 0;
          tag = "R3";
          s  = a + b + c;
          ss = sgn(a) + sgn(b) + c;
          r  = s % 256;
          ac = ((a % 16) + (b % 16) + c > 15) ? 1 : 0;
          cy = (s > 255) ? 1 : 0;
          ov = (ss > 127 || ss < -128) ? 1 : 0;
        end
        2: begin
          tag = "R4";
          s  = a - b - cy;
          ss = sgn(a) - sgn(b) - cy;
          r  = (s + 512) % 256;
          ac = ((a % 16) - (b % 16) - cy < 0) ? 1 : 0;
          ov = (ss > 127 || ss < -128) ? 1 : 0;
          cy = (s < 0) ? 1 : 0;
        end
        3: begin tag = "R5"; r = a | b; end
        4: begin tag = "R5"; r = a & b; end
        5: begin tag = "R5"; r = a ^ b; end
        6: begin tag = "R6"; r = (a + 1) % 256; end
        7: begin tag = "R6"; r = (a + 255) % 256; end
        8: begin tag = "R8"; r = (a * 2) % 256; end
        9: begin tag = "R8"; r = ((a * 2) % 256) + cy; cy = a / 128; end
        10: begin tag = "R9"; r = (a / 2) + (a % 2) * 128; end
        11: begin tag = "R9"; r = (a / 2) + cy * 128; cy = a % 2; end
        12: begin tag = "R10"; r = (a % 16) * 16 + a / 16; end
        13: begin tag = "R7"; cy = (a < b) ? 1 : 0; end
        default: tag = "R12";
      endcase
    end
    m_res = r;
    m_st  = cy * 128 + ac * 64 + ov * 4;
  endtask

  task automatic step(input bit e, input int o, input int a, input int b);
    @(negedge clk);
    compare();
    en   = e;
    op   = 4'(o);
    acc  = 8'(a);
    opnd = 8'(b);
    model(e, o, a, b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    // R3: signed overflow and half carry, no carry out
    step(1, 0, 8'h7F, 8'h01);
    // R5: logic ops keep OV/AC
    step(1, 3, 8'hA0, 8'h0F);
    step(1, 4, 8'hF0, 8'h3C);
    step(1, 5, 8'hFF, 8'h55);
    // R3: carry out, then ADDC uses it after idle cycles (R2)
    step(1, 0, 8'hFF, 8'h02);
    step(0, 0, 8'h00, 8'h00);
    step(0, 2, 8'h12, 8'h34);
    step(1, 1, 8'h10, 8'h20);
    // R6: wraps, flags untouched
    step(1, 0, 8'h80, 8'h80);
    step(1, 6, 8'hFF, 8'h00);
    step(1, 7, 8'h00, 8'h00);
    // R4: borrow with carry set
    step(1, 2, 8'h00, 8'h00);
    step(1, 2, 8'h80, 8'h01);
    step(1, 2, 8'h10, 8'h10);
    // R7: compare both ways
    step(1, 13, 8'h05, 8'h06);
    step(1, 13, 8'h06, 8'h06);
    step(1, 13, 8'h00, 8'hFF);
    // R8/R9: rotates through carry
    step(1, 8, 8'h81, 8'h00);
    step(1, 9, 8'h81, 8'h00);
    step(1, 9, 8'h01, 8'h00);
    step(1, 10, 8'h01, 8'h00);
    step(1, 11, 8'h03, 8'h00);
    step(1, 11, 8'h02, 8'h00);
    // R10: swap
    step(1, 12, 8'hA5, 8'h00);
    // R12: unused codes
    step(1, 14, 8'h11, 8'h22);
    step(1, 15, 8'h33, 8'h44);
    // Random interleaving
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 5) != 0, int'($urandom % 16), int'($urandom % 256),
           int'($urandom % 256));
    end
    step(0, 0, 0, 0);
    // R1: reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    m_res = 0;
    m_st  = 0;
    tag   = "R1";
    #1;
    compare();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule